// File: doc/BRIEF.md
# Ratio-Locked Audio Clock Generator

This block turns one master clock into the set of serial audio timing signals that a serializer and a deserializer need. The master clock reaches it as a one-cycle enable, `mclk_en`, in the system clock domain. Every master cycle is one tick. From these ticks the block derives four signals. The first is a frame strobe at master rate divided by a programmable multiplier M. The second is a bit clock at frame rate times channels times bits per channel. The third is an N*Fs clock at N times the frame rate. The fourth is the per-bit strobes and position indices that a shift register needs. All of them are locked to the same frame.

The ratios are taken from plain configuration inputs. A change starts a sequential evaluation. The evaluation divides M by the bits per frame and by N, and it rejects any setting that no integer divider can realise. A setting that passes waits until the running frame ends, and only then do all the counters switch to it together. A setting that fails is flagged and never applied. A separate watchdog reports whether master ticks are still arriving.

Top module: `audio_ratio_clkgen`

## Requirements
- R1: With a valid setting active, `frame_en` is high for exactly one tick every M ticks, and in that tick `bit_en` is high and both `bit_idx` and `chan_idx` are 0.
- R2: With P = M / (C*W), `bit_en` is high on every tick whose position within the frame is a multiple of P. The position of a tick is the value its index outputs show. `bit_idx` counts 0..W-1 within a channel, and `chan_idx` counts 0..C-1 within a frame.
- R3: The registered `bclk` is high for the first ceil(P/2) ticks of every bit period and low for the rest, so its duty is 50% when P is even. `bclk_fall_en` marks the tick at offset ceil(P/2) within the bit.
- R4: With D = M / N, `nfs_clk` has period D ticks. When `cfg_nfs_inv` is 0 it is high for the first ceil(D/2) ticks of each period, starting high at frame start. When `cfg_nfs_inv` is 1 its polarity is inverted. When D is 1 the non-inverted level stays high.
- R5: A setting is valid only if all of the following hold: M is at least 1; C is 1..256; W is 1..32; N is at least 1; C*W divides M with P at least 2; and N divides M with D in 1..256. `cfg_valid` reports the result.
- R6: Any change on the configuration inputs drives `cfg_valid` low on the next clock edge. For a valid setting, `cfg_valid` is high again within 2*MW+2 clock cycles of the change.
- R7: A newly validated setting takes effect only at a frame boundary. The frame in progress completes with the old length and bit count, and the next frame uses the new ratios.
- R8: An invalid setting is never applied. The outputs keep the ratios of the last valid setting.
- R9: Until a valid setting has been applied, `frame_en`, `bit_en`, `bclk_fall_en`, `bclk` and `nfs_clk` stay low.
- R10: `mclk_ok` is high on the cycle after any tick. It falls after PRES_LIMIT consecutive clock cycles without a tick.
- R11: During reset `cfg_valid`, `mclk_ok`, `bclk`, `nfs_clk` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_en | input | 1 | One-cycle tick per master clock cycle |
| cfg_mult | input | MW | Master cycles per frame (M) |
| cfg_chans | input | CHW | Channels per frame (C), 1..256 |
| cfg_bits | input | BW | Bits per channel (W), 1..32 |
| cfg_nfs_n | input | NW | N*Fs multiplier (N) |
| cfg_nfs_inv | input | 1 | Invert the N*Fs clock |
| cfg_valid | output | 1 | Current setting evaluated and realisable |
| mclk_ok | output | 1 | Master ticks are arriving |
| frame_en | output | 1 | Tick at bit 0 of channel 0 |
| bit_en | output | 1 | Tick at the start of each bit |
| bclk_fall_en | output | 1 | Tick at the falling edge of the bit clock |
| bclk | output | 1 | Bit clock level |
| nfs_clk | output | 1 | N*Fs clock level |
| bit_idx | output | BW | Bit position of the current tick |
| chan_idx | output | CHW | Channel position of the current tick |

## Verification
The bench builds the block with MW=10 and PRES_LIMIT=16, and keeps the default channel, bit and N widths. The narrow multiplier keeps each evaluation short, so the bench can sweep every M from 1 to 36 against every small channel, bit and N combination and compare the validity flag with arithmetic. At the same time, M=600 stays reachable, which is large enough to push D past the 256 limit. The short presence window lets the loss and recovery of master ticks be observed at cycle precision. Whole frames of odd and even bit periods, including D=1, are compared tick by tick with waveforms computed from M, C, W and N.

// File: rtl/audio_ratio_clkgen.sv
module audio_ratio_clkgen #(
  parameter int MW = 16,
  parameter int CHW = 9,
  parameter int BW = 6,
  parameter int NW = 9,
  parameter int PRES_LIMIT = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mclk_en,
  input  logic [MW-1:0]  cfg_mult,
  input  logic [CHW-1:0] cfg_chans,
  input  logic [BW-1:0]  cfg_bits,
  input  logic [NW-1:0]  cfg_nfs_n,
  input  logic           cfg_nfs_inv,
  output logic           cfg_valid,
  output logic           mclk_ok,
  output logic           frame_en,
  output logic           bit_en,
  output logic           bclk_fall_en,
  output logic           bclk,
  output logic           nfs_clk,
  output logic [BW-1:0]  bit_idx,
  output logic [CHW-1:0] chan_idx
);

  localparam int PW  = CHW + BW;
  localparam int DW  = ((MW > PW) ? MW : PW) + 1;
  localparam int CTW = $clog2(MW + 1);
  localparam int PCW = $clog2(PRES_LIMIT + 1);
  localparam int CFW = MW + CHW + BW + NW + 1;

  typedef enum logic [1:0] {C_IDLE, C_DIVB, C_DIVN} calc_t;

  // configuration snapshot and change detect
  logic [CFW-1:0] cfg_now, cfg_q;
  logic [MW-1:0]  q_mult;
  logic [CHW-1:0] q_chans;
  logic [BW-1:0]  q_bits;
  logic [NW-1:0]  q_n;
  logic           q_inv;
  logic [PW-1:0]  bpf_now;
  logic           pre_ok;

  assign cfg_now = {cfg_mult, cfg_chans, cfg_bits, cfg_nfs_n, cfg_nfs_inv};
  assign {q_mult, q_chans, q_bits, q_n, q_inv} = cfg_q;
  assign bpf_now = PW'(cfg_chans) * PW'(cfg_bits);
  assign pre_ok = (cfg_mult != '0) && (cfg_chans != '0) && (int'(cfg_chans) <= 256) &&
                  (cfg_bits != '0) && (int'(cfg_bits) <= 32) && (cfg_nfs_n != '0);

  // shared restoring divider
  calc_t          cstate;
  logic [DW-1:0]  dv_rem, dv_den, dv_shift, r_fin;
  logic [MW-1:0]  dv_quo, q_fin;
  logic [CTW-1:0] dv_cnt;
  logic           dv_ge, dv_last, b_ok, n_ok;
  logic [MW-1:0]  p_per_n, p_nper_n;
  logic           pend;

  assign dv_shift = {dv_rem[DW-2:0], dv_quo[MW-1]};
  assign dv_ge    = dv_shift >= dv_den;
  assign r_fin    = dv_ge ? dv_shift - dv_den : dv_shift;
  assign q_fin    = {dv_quo[MW-2:0], dv_ge};
  assign dv_last  = dv_cnt == CTW'(MW - 1);
  assign n_ok     = b_ok && (r_fin == '0) && (q_fin != '0) && (int'(q_fin) <= 256);

  // active ratios and frame counters
  logic [MW-1:0]  a_mult, a_per, a_nper, hi_len, nhi_len;
  logic [BW-1:0]  a_bits;
  logic [CHW-1:0] a_chans;
  logic           a_inv, run;
  logic [MW-1:0]  f_cnt, ph_cnt, nd_cnt;
  logic [BW-1:0]  b_cnt;
  logic [CHW-1:0] c_cnt;
  logic           tick, f_last, ph_last, b_last, c_last, nd_last, load_now;

  assign tick     = mclk_en & run;
  assign f_last   = f_cnt == a_mult - 1'b1;
  assign ph_last  = ph_cnt == a_per - 1'b1;
  assign b_last   = b_cnt == a_bits - 1'b1;
  assign c_last   = c_cnt == a_chans - 1'b1;
  assign nd_last  = nd_cnt == a_nper - 1'b1;
  assign hi_len   = a_per - (a_per >> 1);
  assign nhi_len  = a_nper - (a_nper >> 1);
  assign load_now = pend & (~run | (tick & f_last));

  assign frame_en     = tick & (f_cnt == '0);
  assign bit_en       = tick & (ph_cnt == '0);
  assign bclk_fall_en = tick & (ph_cnt == hi_len);
  assign bit_idx      = b_cnt;
  assign chan_idx     = c_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cstate    <= C_IDLE;
      cfg_valid <= 1'b0;
      pend      <= 1'b0;
      dv_rem    <= '0;
      dv_quo    <= '0;
      dv_den    <= '0;
      dv_cnt    <= '0;
      b_ok      <= 1'b0;
      p_per_n   <= '0;
      p_nper_n  <= '0;
    end else if (cfg_now != cfg_q) begin
      cfg_q     <= cfg_now;
      cfg_valid <= 1'b0;
      pend      <= 1'b0;
      cstate    <= pre_ok ? C_DIVB : C_IDLE;
      dv_rem    <= '0;
      dv_quo    <= cfg_mult;
      dv_den    <= DW'(bpf_now);
      dv_cnt    <= '0;
    end else begin
      if (load_now) pend <= 1'b0;
      case (cstate)
        C_DIVB, C_DIVN: begin
          dv_rem <= r_fin;
          dv_quo <= q_fin;
          dv_cnt <= dv_cnt + 1'b1;
          if (dv_last) begin
            if (cstate == C_DIVB) begin
              b_ok    <= (r_fin == '0) && (int'(q_fin) >= 2);
              p_per_n <= q_fin;
              dv_rem  <= '0;
              dv_quo  <= q_mult;
              dv_den  <= DW'(q_n);
              dv_cnt  <= '0;
              cstate  <= C_DIVN;
            end else begin
              p_nper_n  <= q_fin;
              cfg_valid <= n_ok;
              pend      <= n_ok;
              cstate    <= C_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      a_mult  <= '0;
      a_per   <= '0;
      a_nper  <= '0;
      a_bits  <= '0;
      a_chans <= '0;
      a_inv   <= 1'b0;
      f_cnt   <= '0;
      ph_cnt  <= '0;
      nd_cnt  <= '0;
      b_cnt   <= '0;
      c_cnt   <= '0;
    end else if (load_now) begin
      run     <= 1'b1;
      a_mult  <= q_mult;
      a_per   <= p_per_n;
      a_nper  <= p_nper_n;
      a_bits  <= q_bits;
      a_chans <= q_chans;
      a_inv   <= q_inv;
      f_cnt   <= '0;
      ph_cnt  <= '0;
      nd_cnt  <= '0;
      b_cnt   <= '0;
      c_cnt   <= '0;
    end else if (tick) begin
      f_cnt  <= f_last ? '0 : f_cnt + 1'b1;
      nd_cnt <= nd_last ? '0 : nd_cnt + 1'b1;
      if (ph_last) begin
        ph_cnt <= '0;
        if (b_last) begin
          b_cnt <= '0;
          c_cnt <= c_last ? '0 : c_cnt + 1'b1;
        end else begin
          b_cnt <= b_cnt + 1'b1;
        end
      end else begin
        ph_cnt <= ph_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk    <= 1'b0;
      nfs_clk <= 1'b0;
    end else if (!run) begin
      bclk    <= 1'b0;
      nfs_clk <= 1'b0;
    end else if (tick) begin
      bclk    <= ph_cnt < hi_len;
      nfs_clk <= (nd_cnt < nhi_len) ^ a_inv;
    end
  end

  // master tick presence
  logic [PCW-1:0] pres_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_cnt <= PCW'(PRES_LIMIT);
      mclk_ok  <= 1'b0;
    end else if (mclk_en) begin
      pres_cnt <= '0;
      mclk_ok  <= 1'b1;
    end else if (int'(pres_cnt) < PRES_LIMIT) begin
      pres_cnt <= pres_cnt + 1'b1;
      if (int'(pres_cnt) + 1 >= PRES_LIMIT) mclk_ok <= 1'b0;
    end
  end

  AST_FRAME_STROBE_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_en |-> bit_en && (bit_idx == '0) && (chan_idx == '0)); // R1
  AST_FRAME_WRAP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    tick && f_last |-> ph_last && b_last && c_last && nd_last); // R2
  AST_BCLK_RISE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> $past(bit_en)); // R3
  AST_ACTIVE_RATIOS_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (int'(a_per) * int'(a_bits) * int'(a_chans) == int'(a_mult)) && (int'(a_per) >= 2) &&
            (a_nper != '0) && (int'(a_nper) <= 256)); // R5
  AST_RELOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && !$stable(a_mult) |-> $past(mclk_en && (f_cnt == a_mult - 1'b1))); // R7
  AST_IDLE_UNTIL_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !frame_en && !bit_en && !bclk); // R9
  AST_TICK_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_en |=> mclk_ok); // R10

endmodule

// File: tb/audio_ratio_clkgen_bench.sv
module audio_ratio_clkgen_bench;
  localparam int MW = 10, CHW = 9, BW = 6, NW = 9, PL = 16;

  logic clk = 1'b0, rst_n = 1'b0, mclk_en = 1'b0;
  logic [MW-1:0] cfg_mult = '0;
  logic [CHW-1:0] cfg_chans = '0;
  logic [BW-1:0] cfg_bits = '0;
  logic [NW-1:0] cfg_nfs_n = '0;
  logic cfg_nfs_inv = 1'b0;
  logic cfg_valid, mclk_ok, frame_en, bit_en, bclk_fall_en, bclk, nfs_clk;
  logic [BW-1:0] bit_idx;
  logic [CHW-1:0] chan_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  audio_ratio_clkgen #(.MW(MW), .CHW(CHW), .BW(BW), .NW(NW), .PRES_LIMIT(PL)) u_audio_ratio_clkgen (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en),
    .cfg_mult(cfg_mult), .cfg_chans(cfg_chans), .cfg_bits(cfg_bits),
    .cfg_nfs_n(cfg_nfs_n), .cfg_nfs_inv(cfg_nfs_inv),
    .cfg_valid(cfg_valid), .mclk_ok(mclk_ok), .frame_en(frame_en), .bit_en(bit_en),
    .bclk_fall_en(bclk_fall_en), .bclk(bclk), .nfs_clk(nfs_clk),
    .bit_idx(bit_idx), .chan_idx(chan_idx));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int m, input int c, input int w, input int n, input bit inv);
    @(negedge clk);
    cfg_mult = MW'(m); cfg_chans = CHW'(c); cfg_bits = BW'(w);
    cfg_nfs_n = NW'(n); cfg_nfs_inv = inv;
  endtask

  function automatic bit exp_valid(input int m, input int c, input int w, input int n);
    int b;
    b = c * w;
    if (m < 1 || c < 1 || c > 256 || w < 1 || w > 32 || n < 1) return 1'b0;
    if (m % b != 0 || m / b < 2) return 1'b0;
    if (m % n != 0 || m / n > 256) return 1'b0;
    return 1'b1;
  endfunction

  // advance to the next negedge with frame_en; returns negedges advanced and bit_en seen
  task automatic wait_frame(output int cyc, output int bits);
    cyc = 0; bits = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (bit_en) bits++;
    end while (!frame_en && cyc < 5000);
  endtask

  task automatic check_wave(input int m, input int c, input int w, input int n, input bit inv);
    int p, d, cy, bt;
    p = m / (c * w);
    d = m / n;
    set_cfg(m, c, w, n, inv);
    repeat (24) @(negedge clk);
    chk(cfg_valid == 1'b1, $sformatf("R5 valid before wave m=%0d", m), cfg_valid, 1);
    wait_frame(cy, bt);
    wait_frame(cy, bt);
    for (int j = 0; j < m; j++) begin
      int pm;
      pm = (j + m - 1) % m;
      chk(frame_en == (j == 0), $sformatf("R1 frame_en m=%0d j=%0d", m, j), frame_en, j == 0);
      chk(bit_en == (j % p == 0), $sformatf("R2 bit_en m=%0d j=%0d", m, j), bit_en, j % p == 0);
      chk(int'(bit_idx) == (j / p) % w, $sformatf("R2 bit_idx m=%0d j=%0d", m, j), bit_idx, (j / p) % w);
      chk(int'(chan_idx) == j / (p * w), $sformatf("R2 chan_idx m=%0d j=%0d", m, j), chan_idx, j / (p * w));
      chk(bclk == ((pm % p) < p - p / 2), $sformatf("R3 bclk m=%0d j=%0d", m, j), bclk, (pm % p) < p - p / 2);
      chk(bclk_fall_en == (j % p == p - p / 2), $sformatf("R3 fall_en m=%0d j=%0d", m, j),
          bclk_fall_en, j % p == p - p / 2);
      chk(nfs_clk == (((pm % d) < d - d / 2) ^ inv), $sformatf("R4 nfs m=%0d j=%0d", m, j),
          nfs_clk, ((pm % d) < d - d / 2) ^ inv);
      @(negedge clk);
    end
    chk(frame_en == 1'b1, $sformatf("R1 next frame m=%0d", m), frame_en, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cy, bt;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(cfg_valid == 1'b0, "R11 cfg_valid in reset", cfg_valid, 0);
    chk(mclk_ok == 1'b0, "R11 mclk_ok in reset", mclk_ok, 0);
    chk(bclk == 1'b0 && nfs_clk == 1'b0, "R11 clocks in reset", {bclk, nfs_clk}, 0);
    chk(frame_en == 1'b0 && bit_en == 1'b0, "R11 strobes in reset", {frame_en, bit_en}, 0);
    rst_n = 1'b1;
    mclk_en = 1'b1;

    // R9: idle with no valid setting
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (frame_en || bit_en || bclk_fall_en || bclk || nfs_clk) seen++;
      end
      chk(seen == 0, "R9 outputs idle before valid setting", seen, 0);
      chk(mclk_ok == 1'b1, "R10 mclk_ok with ticks", mclk_ok, 1);
    end

    // R5: validity sweep
    for (int m = 1; m <= 36; m++)
      for (int c = 1; c <= 4; c++)
        for (int w = 1; w <= 4; w++)
          for (int n = 1; n <= 3; n++) begin
            set_cfg(m, c, w, n, 1'b0);
            repeat (24) @(negedge clk);
            chk(cfg_valid == exp_valid(m, c, w, n),
                $sformatf("R5 sweep m=%0d c=%0d w=%0d n=%0d", m, c, w, n), cfg_valid, exp_valid(m, c, w, n));
          end

    // R5: range edges
    begin
      int ev[8][4] = '{'{64, 0, 4, 2}, '{64, 257, 4, 2}, '{64, 2, 0, 2}, '{66, 1, 33, 2},
                       '{0, 2, 4, 2}, '{64, 2, 4, 0}, '{600, 2, 3, 2}, '{600, 2, 3, 3}};
      for (int k = 0; k < 8; k++) begin
        set_cfg(ev[k][0], ev[k][1], ev[k][2], ev[k][3], 1'b0);
        repeat (24) @(negedge clk);
        chk(cfg_valid == exp_valid(ev[k][0], ev[k][1], ev[k][2], ev[k][3]),
            $sformatf("R5 edge m=%0d c=%0d w=%0d n=%0d", ev[k][0], ev[k][1], ev[k][2], ev[k][3]),
            cfg_valid, exp_valid(ev[k][0], ev[k][1], ev[k][2], ev[k][3]));
      end
    end

    // R6: evaluation latency
    chk(cfg_valid == 1'b1, "R6 valid before change", cfg_valid, 1);
    set_cfg(48, 2, 4, 4, 1'b0);
    @(negedge clk);
    chk(cfg_valid == 1'b0, "R6 valid drops after change", cfg_valid, 0);
    repeat (2 * MW + 1) @(negedge clk);
    chk(cfg_valid == 1'b1, "R6 valid within 2*MW+2 cycles", cfg_valid, 1);

    // R1-R4: whole frames
    check_wave(48, 2, 4, 4, 1'b0);
    check_wave(40, 1, 4, 5, 1'b1);
    check_wave(42, 2, 3, 6, 1'b0);
    check_wave(8, 1, 1, 8, 1'b0);
    check_wave(600, 2, 3, 3, 1'b0);

    // R7: change mid-frame, old frame completes
    repeat (49) @(negedge clk);
    set_cfg(48, 2, 4, 4, 1'b0);
    wait_frame(cy, bt);
    chk(cy + 50 == 600, "R7 frame in progress keeps old length", cy + 50, 600);
    chk(bt == 6, "R7 frame in progress keeps old bit count", bt, 6);
    wait_frame(cy, bt);
    chk(cy == 48, "R7 first new frame length", cy, 48);
    chk(bt == 8, "R7 first new frame bit count", bt, 8);

    // R8: invalid setting ignored
    set_cfg(48, 2, 4, 5, 1'b0);
    repeat (24) @(negedge clk);
    chk(cfg_valid == 1'b0, "R8 invalid flagged", cfg_valid, 0);
    wait_frame(cy, bt);
    wait_frame(cy, bt);
    chk(cy == 48, "R8 frame length unchanged", cy, 48);
    chk(bt == 8, "R8 bit count unchanged", bt, 8);

    // R10: presence watchdog
    @(negedge clk);
    mclk_en = 1'b0;
    repeat (PL - 1) @(negedge clk);
    chk(mclk_ok == 1'b1, "R10 still present before limit", mclk_ok, 1);
    chk(frame_en == 1'b0 && bit_en == 1'b0, "R10 no strobes without ticks", {frame_en, bit_en}, 0);
    @(negedge clk);
    chk(mclk_ok == 1'b0, "R10 lost at limit", mclk_ok, 0);
    mclk_en = 1'b1;
    @(negedge clk);
    chk(mclk_ok == 1'b1, "R10 back after one tick", mclk_ok, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule